// File: doc/BRIEF.md
# MDIO Management Command Controller

This block drives the two-wire station-management bus of an Ethernet PHY. A host loads a 16-bit data value, a 5-bit PHY address and a 5-bit register number. Setting a write or read command bit starts the access. The block then generates a clause-22 management frame on MDC/MDIO, with or without a 32-bit preamble. For a read, it deserializes the 16 returned data bits into the same data field the host wrote.

While a host access is pending or on the wire, a busy flag stays high. When the frame ends, busy clears and a sticky completion flag is set. A read whose PHY fails to pull MDIO low during the second turnaround bit sets a read-error status bit and a sticky error flag. Each flag has its own enable into the interrupt output. A second internal requester, such as a periodic status poller, can request read frames. It wins over a pending host command whenever the bus is idle, so the host must rely on the busy flag or the interrupt rather than on a fixed delay.

MDC is derived from the system clock by dividing by twice a half-period parameter. It stays low between frames.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: A write frame, after any preamble, carries start 01, opcode 01, the PHY address (5 bits, MSB first), the register number (5 bits, MSB first), turnaround 10 and the 16 data bits MSB first, and MDIO is driven (mdio_oe=1) for every bit of it.
- R2: A read frame carries opcode 10. mdio_oe drops from the first turnaround bit (body bit 14) to the end of the frame. MDIO is sampled on each MDC rise of body bits 16..31 and shifted in MSB first. data_out holds the result once busy is 0.
- R3: Each frame bit lasts 2*CLK_HALF clocks: MDC is low for the first CLK_HALF clocks and high for the next CLK_HALF. MDIO changes only when MDC falls. MDC is 0 whenever no frame is running.
- R4: With cmd_nopre=0 a host frame is preceded by 32 ones (64 bits in total). With cmd_nopre=1 there is no preamble (32 bits). busy is therefore high for 1+2*CLK_HALF*64 or 1+2*CLK_HALF*32 clocks when the host has no competition.
- R5: A command is accepted when cmd_we=1, busy=0 and cmd_wr or cmd_rd is 1. busy rises the cycle after acceptance and falls the cycle after the last bit ends. A cmd_we while busy=1 changes nothing: no field is loaded and no frame follows. Reset leaves busy, mdc, mdio_oe and irq at 0.
- R6: Every host frame end sets done_flag, which stays set until clr_done. When the end and clr_done fall in the same cycle, the flag ends set. done_flag contributes to irq only while en_done=1.
- R7: A host read that samples MDIO=1 in body bit 15 sets rd_err and err_flag. err_flag is sticky until clr_err and reaches irq only while en_err=1. rd_err returns to 0 when the next command is accepted.
- R8: If poll_req=1 while no frame runs, a poll frame starts before any pending host command. poll_ack is 1 in the cycle before that start. A poll frame is always a preamble read of poll_phy/poll_reg. Its end gives a one-cycle poll_done, with poll_data and poll_err valid in that cycle, and leaves done_flag, err_flag, rd_err and data_out untouched.
- R9: When cmd_wr and cmd_rd are both 1, the command is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_data | input | 16 | Data field for a write |
| cmd_phy | input | 5 | PHY address field |
| cmd_reg | input | 5 | Register number field |
| cmd_wr | input | 1 | Write command bit |
| cmd_rd | input | 1 | Read command bit |
| cmd_nopre | input | 1 | 1 = omit the preamble |
| busy | output | 1 | Host access pending or on the wire |
| data_out | output | 16 | Data field (written value or read result) |
| rd_err | output | 1 | Last host read had a turnaround error |
| en_done | input | 1 | Completion interrupt enable |
| en_err | input | 1 | Read-error interrupt enable |
| clr_done | input | 1 | Clear completion flag |
| clr_err | input | 1 | Clear read-error flag |
| done_flag | output | 1 | Sticky completion flag |
| err_flag | output | 1 | Sticky read-error flag |
| irq | output | 1 | Interrupt output |
| poll_req | input | 1 | Internal requester wants a read frame |
| poll_phy | input | 5 | PHY address for the poll read |
| poll_reg | input | 5 | Register number for the poll read |
| poll_ack | output | 1 | Poll request taken; frame starts next cycle |
| poll_done | output | 1 | One-cycle pulse at poll frame end |
| poll_data | output | 16 | Poll read data, valid with poll_done |
| poll_err | output | 1 | Poll turnaround error, valid with poll_done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A host frame ending can coincide with a software clear of the completion flag, and the two act on the same sticky bit. The bench provokes this by deriving clr_done from its reference model: the clear is raised only in the cycle before the model predicts the last MDC fall of a host frame. The result is judged by done_flag reading 1 afterwards, with the model and the design compared on every clock. A second collision is a poll request and a host command arriving in the same idle cycle. It is judged by poll_done coming while busy is still high and no host flag changes.

// File: rtl/mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl #(
  parameter int CLK_HALF = 40,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [15:0] cmd_data,
  input  logic [4:0]  cmd_phy,
  input  logic [4:0]  cmd_reg,
  input  logic        cmd_wr,
  input  logic        cmd_rd,
  input  logic        cmd_nopre,
  output logic        busy,
  output logic [15:0] data_out,
  output logic        rd_err,
  input  logic        en_done,
  input  logic        en_err,
  input  logic        clr_done,
  input  logic        clr_err,
  output logic        done_flag,
  output logic        err_flag,
  output logic        irq,
  input  logic        poll_req,
  input  logic [4:0]  poll_phy,
  input  logic [4:0]  poll_reg,
  output logic        poll_ack,
  output logic        poll_done,
  output logic [15:0] poll_data,
  output logic        poll_err,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FULL = PRE_LEN + 32;
  localparam int IW   = $clog2(FULL);
  localparam int DW   = $clog2(CLK_HALF) + 1;

  logic          act, own_poll, f_rd, f_nopre, mdc_q, ta_err;
  logic [4:0]    f_phy, f_reg;
  logic [IW-1:0] idx;
  logic [DW-1:0] div;
  logic [15:0]   sh, dat_q;
  logic          h_pend, h_rd, h_nopre;
  logic [4:0]    h_phy, h_reg;

  logic acc, start_p, start_h, tick, rise, fall, last, fin, h_fin, in_pre;
  logic [4:0]  b;
  logic [31:0] body;

  assign busy    = h_pend | (act & ~own_poll);
  assign acc     = cmd_we & ~busy & (cmd_wr | cmd_rd);
  assign start_p = ~act & poll_req;
  assign start_h = ~act & ~poll_req & h_pend;
  assign poll_ack = start_p;

  assign tick  = act & (div == DW'(CLK_HALF - 1));
  assign rise  = tick & ~mdc_q;
  assign fall  = tick & mdc_q;
  assign last  = idx == (f_nopre ? IW'(31) : IW'(FULL - 1));
  assign fin   = fall & last;
  assign h_fin = fin & ~own_poll;

  assign in_pre = ~f_nopre & (idx < IW'(PRE_LEN));
  assign b      = 5'(idx - (f_nopre ? IW'(0) : IW'(PRE_LEN)));
  assign body   = {2'b01, f_rd ? 2'b10 : 2'b01, f_phy, f_reg, 2'b10, dat_q};

  assign mdc     = mdc_q;
  assign mdio_o  = ~act | in_pre | body[5'd31 - b];
  assign mdio_oe = act & ~(f_rd & ~in_pre & (b >= 5'd14));

  assign data_out  = dat_q;
  assign poll_data = sh;
  assign poll_err  = ta_err;
  assign irq = (done_flag & en_done) | (err_flag & en_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0; own_poll <= 1'b0; f_rd <= 1'b0; f_nopre <= 1'b0;
      f_phy <= '0; f_reg <= '0; idx <= '0; div <= '0; mdc_q <= 1'b0;
      ta_err <= 1'b0; sh <= '0;
    end else if (start_p | start_h) begin
      act      <= 1'b1;
      own_poll <= start_p;
      f_rd     <= start_p | h_rd;
      f_nopre  <= start_h & h_nopre;
      f_phy    <= start_p ? poll_phy : h_phy;
      f_reg    <= start_p ? poll_reg : h_reg;
      idx      <= '0;
      div      <= '0;
      mdc_q    <= 1'b0;
      ta_err   <= 1'b0;
    end else if (act) begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (fall) begin
        if (last) act <= 1'b0;
        else      idx <= idx + 1'b1;
      end
      if (rise & f_rd & ~in_pre & (b == 5'd15)) ta_err <= mdio_i;
      if (rise & f_rd & ~in_pre & (b >= 5'd16)) sh <= {sh[14:0], mdio_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_pend <= 1'b0; h_rd <= 1'b0; h_nopre <= 1'b0;
      h_phy <= '0; h_reg <= '0; dat_q <= '0; rd_err <= 1'b0;
    end else begin
      if (acc) begin
        h_pend  <= 1'b1;
        h_rd    <= cmd_rd & ~cmd_wr;
        h_nopre <= cmd_nopre;
        h_phy   <= cmd_phy;
        h_reg   <= cmd_reg;
        dat_q   <= cmd_data;
        rd_err  <= 1'b0;
      end else if (start_h) begin
        h_pend <= 1'b0;
      end
      if (h_fin & f_rd) begin
        dat_q  <= sh;
        rd_err <= ta_err;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0; err_flag <= 1'b0; poll_done <= 1'b0;
    end else begin
      poll_done <= fin & own_poll;
      if (h_fin)         done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
      if (h_fin & f_rd & ta_err) err_flag <= 1'b1;
      else if (clr_err)          err_flag <= 1'b0;
    end
  end
endmodule

module mdio_cmd_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic act,
  input logic mdc,
  input logic busy,
  input logic done_flag,
  input logic err_flag,
  input logic clr_done,
  input logic poll_done,
  input logic mdio_oe,
  input logic f_rd,
  input logic h_fin
);
  assert_mdc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !mdc);
  assert_write_driven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !f_rd) |-> mdio_oe);
  assert_busy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_fin |=> !busy);
  assert_busy_fall_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_flag);
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_done) |=> done_flag);
  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> done_flag);
  assert_poll_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    poll_done |=> !poll_done);
endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act(act), .mdc(mdc), .busy(busy),
  .done_flag(done_flag), .err_flag(err_flag), .clr_done(clr_done),
  .poll_done(poll_done), .mdio_oe(mdio_oe), .f_rd(f_rd), .h_fin(h_fin)
);

// File: tb/sim_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_cmd_ctrl;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, cmd_wr = 0, cmd_rd = 0, cmd_nopre = 0;
  logic [15:0] cmd_data = '0;
  logic [4:0] cmd_phy = '0, cmd_reg = '0, poll_phy = '0, poll_reg = '0;
  logic en_done = 0, en_err = 0, clr_task = 0, clr_err = 0, clr_coll = 0;
  logic poll_req = 0;
  logic mdio_i;
  logic clr_done;
  logic busy, rd_err, done_flag, err_flag, irq, poll_ack, poll_done, poll_err;
  logic mdc, mdio_o, mdio_oe;
  logic [15:0] data_out, poll_data;

  assign clr_done = clr_task | clr_coll;

  mdio_cmd_ctrl #(.CLK_HALF(H)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wr(cmd_wr), .cmd_rd(cmd_rd),
    .cmd_nopre(cmd_nopre), .busy(busy), .data_out(data_out), .rd_err(rd_err),
    .en_done(en_done), .en_err(en_err), .clr_done(clr_done), .clr_err(clr_err),
    .done_flag(done_flag), .err_flag(err_flag), .irq(irq), .poll_req(poll_req),
    .poll_phy(poll_phy), .poll_reg(poll_reg), .poll_ack(poll_ack),
    .poll_done(poll_done), .poll_data(poll_data), .poll_err(poll_err),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit collide = 0, inj_err = 0;

  // reference model state
  bit m_act, m_poll, m_rd, m_nopre, m_pend, h_rd, h_nopre;
  bit m_done, m_errf, m_rderr, m_pdone, m_perr;
  bit o_act, o_pend, o_busy, fin;
  int m_c, m_len;
  logic [4:0] m_phy, m_reg, h_phy, h_reg;
  logic [15:0] m_dat, m_pdata;

  function automatic logic [15:0] phyval(logic [4:0] p, logic [4:0] r);
    return {3'b101, p, r, 3'b011};
  endfunction

  function automatic int body_idx();
    int k = m_c / (2 * H);
    return m_nopre ? k : k - 32;
  endfunction

  function automatic logic exp_bit();
    int bi = body_idx();
    logic [31:0] w;
    if (bi < 0) return 1'b1;
    w = {2'b01, m_rd ? 2'b10 : 2'b01, m_phy, m_reg, 2'b10, m_dat};
    return w[31 - bi];
  endfunction

  function automatic logic phy_drive();
    int bi;
    logic [15:0] v;
    if (!m_act || !m_rd || inj_err) return 1'b1;
    bi = body_idx();
    v = phyval(m_phy, m_reg);
    if (bi == 15) return 1'b0;
    if (bi >= 16) return v[31 - bi];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_act = 0; m_poll = 0; m_rd = 0; m_nopre = 0; m_pend = 0; h_rd = 0;
      h_nopre = 0; m_done = 0; m_errf = 0; m_rderr = 0; m_pdone = 0; m_perr = 0;
      m_c = 0; m_len = 64; m_phy = 0; m_reg = 0; h_phy = 0; h_reg = 0;
      m_dat = 0; m_pdata = 0;
      mdio_i <= 1'b1;
    end else begin
      o_act = m_act; o_pend = m_pend; o_busy = m_pend || (m_act && !m_poll);
      m_pdone = 0;
      fin = m_act && (m_c + 1 == 2 * H * m_len);
      if (clr_done) m_done = 0;
      if (clr_err) m_errf = 0;
      if (m_act) begin
        m_c++;
        if (fin) begin
          m_act = 0;
          if (m_poll) begin
            m_pdone = 1; m_perr = inj_err;
            m_pdata = inj_err ? 16'hFFFF : phyval(m_phy, m_reg);
          end else begin
            m_done = 1;
            if (m_rd) begin
              m_dat = inj_err ? 16'hFFFF : phyval(m_phy, m_reg);
              m_rderr = inj_err;
              if (inj_err) m_errf = 1;
            end
          end
        end
      end
      if (!o_act) begin
        if (poll_req) begin
          m_act = 1; m_poll = 1; m_rd = 1; m_nopre = 0; m_c = 0; m_len = 64;
          m_phy = poll_phy; m_reg = poll_reg;
        end else if (o_pend) begin
          m_act = 1; m_poll = 0; m_rd = h_rd; m_nopre = h_nopre; m_c = 0;
          m_len = h_nopre ? 32 : 64; m_phy = h_phy; m_reg = h_reg; m_pend = 0;
        end
      end
      if (cmd_we && !o_busy && (cmd_wr || cmd_rd)) begin
        m_pend = 1; h_rd = cmd_rd && !cmd_wr; h_nopre = cmd_nopre;
        h_phy = cmd_phy; h_reg = cmd_reg; m_dat = cmd_data; m_rderr = 0;
      end
      mdio_i <= phy_drive();
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (got cycle %0d, exp < 150000)", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  always @(negedge clk)
    clr_coll <= collide && m_act && !m_poll && (m_c + 1 == 2 * H * m_len);

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h (t=%0t)", tag, got, exp, $time);
    end
  endtask

  // lockstep comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic e_mdc, e_oe, e_irq;
      e_mdc = m_act && (((m_c / H) % 2) == 1);
      e_oe  = m_act && !(m_rd && body_idx() >= 14);
      e_irq = (m_done && en_done) || (m_errf && en_err);
      chk(busy == (m_pend || (m_act && !m_poll)), "R5 busy", busy, m_pend || (m_act && !m_poll));
      chk(mdc == e_mdc, "R3 mdc", mdc, e_mdc);
      chk(mdio_oe == e_oe, "R2 mdio_oe", mdio_oe, e_oe);
      if (e_oe) chk(mdio_o == exp_bit(), "R1 mdio_o", mdio_o, exp_bit());
      chk(data_out == m_dat, "R2 data_out", data_out, m_dat);
      chk(done_flag == m_done, "R6 done_flag", done_flag, m_done);
      chk(err_flag == m_errf, "R7 err_flag", err_flag, m_errf);
      chk(rd_err == m_rderr, "R7 rd_err", rd_err, m_rderr);
      chk(irq == e_irq, "R6 irq", irq, e_irq);
      chk(poll_ack == (!m_act && poll_req), "R8 poll_ack", poll_ack, !m_act && poll_req);
      chk(poll_done == m_pdone, "R8 poll_done", poll_done, m_pdone);
      if (m_pdone) begin
        chk(poll_data == m_pdata, "R8 poll_data", poll_data, m_pdata);
        chk(poll_err == m_perr, "R8 poll_err", poll_err, m_perr);
      end
    end
  end

  task automatic host_cmd(input bit wr, input bit rd, input bit nopre,
                          input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    @(negedge clk);
    cmd_we = 1; cmd_wr = wr; cmd_rd = rd; cmd_nopre = nopre;
    cmd_phy = p; cmd_reg = r; cmd_data = d;
    @(negedge clk);
    cmd_we = 0; cmd_wr = 0; cmd_rd = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic clear_done();
    @(negedge clk); clr_task = 1;
    @(negedge clk); clr_task = 0;
  endtask

  int n;

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && mdc == 0 && mdio_oe == 0 && irq == 0, "R5 reset state",
        {busy, mdc, mdio_oe, irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // write with preamble, completion interrupt enabled
    en_done = 1;
    host_cmd(1, 0, 0, 5'd5, 5'd3, 16'hA5C3);
    wait_idle(n);
    chk(n == 1 + 2 * H * 64, "R4 preamble frame length", n, 1 + 2 * H * 64);
    chk(done_flag == 1 && irq == 1, "R6 completion irq", {done_flag, irq}, 2'b11);
    clear_done();
    chk(done_flag == 0 && irq == 0, "R6 cleared", {done_flag, irq}, 0);

    // read without preamble
    host_cmd(0, 1, 1, 5'd1, 5'd2, 16'h0000);
    wait_idle(n);
    chk(n == 1 + 2 * H * 32, "R4 suppressed frame length", n, 1 + 2 * H * 32);
    chk(data_out == phyval(5'd1, 5'd2), "R2 read data", data_out, phyval(5'd1, 5'd2));
    clear_done();

    // read error, enables off, then error enable on
    en_done = 0;
    inj_err = 1;
    host_cmd(0, 1, 0, 5'd9, 5'd17, 16'h0000);
    wait_idle(n);
    inj_err = 0;
    chk(rd_err == 1 && err_flag == 1, "R7 error flagged", {rd_err, err_flag}, 2'b11);
    chk(irq == 0, "R7 irq masked", irq, 0);
    @(negedge clk); en_err = 1;
    @(negedge clk);
    chk(irq == 1, "R7 irq enabled", irq, 1);
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0; en_err = 0;
    clear_done();

    // command while busy is ignored; new command clears rd_err
    host_cmd(0, 1, 0, 5'd3, 5'd4, 16'h0000);
    chk(rd_err == 0, "R7 rd_err cleared on accept", rd_err, 0);
    repeat (5) @(negedge clk);
    host_cmd(1, 0, 1, 5'd7, 5'd7, 16'h1234);
    wait_idle(n);
    chk(data_out == phyval(5'd3, 5'd4), "R5 busy write ignored", data_out, phyval(5'd3, 5'd4));
    repeat (40) @(negedge clk);
    chk(busy == 0 && mdc == 0, "R5 no extra frame", {busy, mdc}, 0);
    clear_done();

    // both command bits -> write
    host_cmd(1, 1, 1, 5'd2, 5'd6, 16'hBEEF);
    wait_idle(n);
    chk(data_out == 16'hBEEF, "R9 write precedence", data_out, 16'hBEEF);
    clear_done();

    // poll and host arrive together: poll first
    @(negedge clk);
    poll_req = 1; poll_phy = 5'd7; poll_reg = 5'd1;
    cmd_we = 1; cmd_rd = 1; cmd_nopre = 0; cmd_phy = 5'd2; cmd_reg = 5'd9;
    @(negedge clk);
    cmd_we = 0; cmd_rd = 0; poll_req = 0;
    while (!poll_done) @(negedge clk);
    chk(busy == 1 && done_flag == 0, "R8 host waits behind poll", {busy, done_flag}, 2'b10);
    chk(poll_data == phyval(5'd7, 5'd1), "R8 poll result", poll_data, phyval(5'd7, 5'd1));
    wait_idle(n);
    chk(data_out == phyval(5'd2, 5'd9), "R8 host read after poll", data_out, phyval(5'd2, 5'd9));
    clear_done();

    // clear and completion in the same cycle
    collide = 1;
    host_cmd(1, 0, 1, 5'd4, 5'd4, 16'h0F0F);
    wait_idle(n);
    @(negedge clk);
    collide = 0;
    chk(done_flag == 1, "R6 set beats clear", done_flag, 1);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule